// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock Output

This block is a 16-bit timer/counter paired with a 16-bit reload value, held as two bytes. It counts either internal ticks from an upstream prescaler or falling edges on an external count pin. Whenever it wraps, it reloads itself. Upward counting wraps past all-ones and reloads from the reload value. Downward counting wraps when the count equals the reload value and then reloads all-ones.

A mode bit enables bidirectional operation. Once enabled, a direction pin chooses up or down on each count event, and a second flag toggles on every wrap. That flag then behaves as a 17th count bit.

A separate mode bit turns the block into a clock generator. The output pin toggles on every wrap, and the count always runs upward off the internal tick. Software reaches the block through a byte-wide write port and a combinational read port. The interrupt request is a gated OR of the two flags.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset every register reads zero, and the outputs ovf_o, xflg_o, irq_o and clkout_o are low.
- R2: With run (control bit 0) set, each count event moves the count by exactly one. With run clear, or with no event, the count holds.
- R3: Counting up from FFFFh loads the reload value (address 4 is the low byte, address 5 the high byte) and sets the overflow flag (control bit 7).
- R4: While down-enable (mode bit 1) is 0, the timer counts up whatever the level of the direction pin.
- R5: While down-enable is 1 and clock-out is off, a high direction pin counts up and a low one counts down. The pin is registered once, so a change applies to count events from the second clock edge on.
- R6: Counting down with the count equal to the reload value loads FFFFh and sets the overflow flag. Any other down event decrements the count.
- R7: The external flag (control bit 6) toggles on every wrap in either direction while down-enable is 1 and clock-out is off. Otherwise wraps leave it unchanged.
- R8: While clock-out (mode bit 0) is 1, the timer counts up on the internal tick, ignoring the direction pin and the external-source select, and clkout_o toggles on each wrap. While clock-out is 0, clkout_o holds.
- R9: With external source (control bit 1) set, each falling edge on cnt_pin_i is one count event after a two-flop synchronizer and an edge detector, and tick_i is ignored.
- R10: A control write loads both flags from the written data. A wrap in the same cycle still sets the overflow flag and still applies the toggle of R7 on top of the written value.
- R11: irq_o is high exactly when interrupt enable (control bit 2) is set and either flag is set.
- R12: A write to a count byte (address 2 low, address 3 high) takes priority over a count event in the same cycle, and that event causes no wrap. Addresses 6 and 7 read zero, and mode reads back with its unused bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable from the clock divider |
| cnt_pin_i | input | 1 | External count input, falling edge counts |
| dir_pin_i | input | 1 | Direction input, high counts up |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | HALF_W (8) | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | HALF_W (8) | Register read data, combinational |
| ovf_o | output | 1 | Overflow flag |
| xflg_o | output | 1 | External flag (17th count bit in up/down mode) |
| irq_o | output | 1 | Interrupt request |
| clkout_o | output | 1 | Clock output, toggles on each wrap in clock-out mode |

## Verification
The bench builds the block with its defaults: a byte width of 8, which gives a 16-bit count, and a two-stage synchronizer. Because the count is only 16 bits, writing the count next to FFFFh or next to the reload value reaches every wrap boundary in a few ticks. The up wrap, the down match, an all-ones reload and the flag races can therefore all be hit inside a short random run. The synchronizer depth of two sets the fixed three-edge latency from a falling external edge to the count change, and the bench models that latency cycle by cycle.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_RLD_LO = 3'd4,
    A_RLD_HI = 3'd5
  } reg_addr_e;

  // control register bit positions
  localparam int CB_RUN = 0;
  localparam int CB_EXT = 1;
  localparam int CB_IEN = 2;
  localparam int CB_XF  = 6;
  localparam int CB_OVF = 7;

  // mode register bit positions
  localparam int MB_CLKO = 0;
  localparam int MB_DOWN = 1;

  typedef struct packed {
    logic run;
    logic ext_sel;
    logic irq_en;
    logic clko_en;
    logic down_en;
  } cfg_t;

endpackage

// File: rtl/tmr_event_gen.sv
module tmr_event_gen
  import updn_tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic tick_i,
  input  logic pin_i,
  input  logic dir_i,
  output logic evt_o,
  output logic up_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   dir_q;
  logic                   started_q;
  logic                   fall_edge;
  logic                   src_evt;
  logic                   use_pin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '0;
      prev_q    <= 1'b0;
      dir_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q    <= sync_q[TOP];
      dir_q     <= dir_i;
      started_q <= 1'b1;
    end
  end

  assign fall_edge = prev_q & ~sync_q[TOP];
  assign use_pin   = cfg_i.ext_sel & ~cfg_i.clko_en;
  assign src_evt   = use_pin ? fall_edge : tick_i;
  assign evt_o     = cfg_i.run & src_evt;
  assign up_o      = cfg_i.clko_en | ~cfg_i.down_en | dir_q;

  // direction follows the pin one edge late in up/down mode
  p_dir_sampled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && cfg_i.down_en && !cfg_i.clko_en) |-> (up_o == $past(dir_i)))
    else $error("p_dir_sampled_r5");

  // without down-enable the count direction is always up
  p_up_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.down_en |-> up_o)
    else $error("p_up_only_r4");

  // the external source never counts unless its synchronized level fell
  p_ext_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && use_pin && evt_o) |-> (!sync_q[TOP] && $past(sync_q[TOP])))
    else $error("p_ext_edge_r9");

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_i,
  input  logic                up_i,
  input  logic [2*HALF_W-1:0] rld_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] cnt_o,
  output logic                wrap_o
);

  localparam int W = 2 * HALF_W;

  // {wrap, next} for an upward step
  function automatic logic [W:0] step_up(logic [W-1:0] c, logic [W-1:0] r);
    if (c == '1) return {1'b1, r};
    return {1'b0, c + W'(1)};
  endfunction

  // {wrap, next} for a downward step; only a match with the reload wraps
  function automatic logic [W:0] step_down(logic [W-1:0] c, logic [W-1:0] r);
    if (c == r) return {1'b1, {W{1'b1}}};
    return {1'b0, c - W'(1)};
  endfunction

  logic [W-1:0] cnt_q;
  logic [W:0]   step;
  logic         wr_any;

  assign wr_any = wr_lo_i | wr_hi_i;
  assign step   = up_i ? step_up(cnt_q, rld_i) : step_down(cnt_q, rld_i);
  assign wrap_o = evt_i & ~wr_any & step[W];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q[HALF_W-1:0] <= wdata_i;
    end else if (wr_hi_i) begin
      cnt_q[W-1:HALF_W] <= wdata_i;
    end else if (evt_i) begin
      cnt_q <= step[W-1:0];
    end
  end

  p_step_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && up_i && cnt_q != '1 && !wr_any) |=> (cnt_q == $past(cnt_q) + W'(1)))
    else $error("p_step_up_r2");

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !wr_any) |=> $stable(cnt_q))
    else $error("p_hold_r2");

  p_up_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && up_i && cnt_q == '1 && !wr_any) |=> (cnt_q == $past(rld_i)))
    else $error("p_up_reload_r3");

  p_down_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !up_i && cnt_q == rld_i && !wr_any) |=> (cnt_q == '1))
    else $error("p_down_match_r6");

  p_write_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_q[HALF_W-1:0] == $past(wdata_i)))
    else $error("p_write_wins_r12");

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import updn_tmr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   wr_addr_i,
  input  logic [HALF_W-1:0]   wr_data_i,
  input  logic [REG_AW-1:0]   rd_addr_i,
  output logic [HALF_W-1:0]   rd_data_o,
  input  logic [2*HALF_W-1:0] cnt_i,
  input  logic                wrap_i,
  output cfg_t                cfg_o,
  output logic [2*HALF_W-1:0] rld_o,
  output logic                ovf_o,
  output logic                xf_o,
  output logic                wr_cnt_lo_o,
  output logic                wr_cnt_hi_o
);

  logic              run_q, ext_q, ien_q, clko_q, down_q;
  logic              ovf_q, xf_q;
  logic [HALF_W-1:0] rld_lo_q, rld_hi_q;
  logic              wr_ctrl, wr_mode, wr_rlo, wr_rhi;
  logic              updn_mode;
  logic              ovf_base, xf_base;

  assign wr_ctrl     = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_mode     = wr_en_i && (wr_addr_i == A_MODE);
  assign wr_cnt_lo_o = wr_en_i && (wr_addr_i == A_CNT_LO);
  assign wr_cnt_hi_o = wr_en_i && (wr_addr_i == A_CNT_HI);
  assign wr_rlo      = wr_en_i && (wr_addr_i == A_RLD_LO);
  assign wr_rhi      = wr_en_i && (wr_addr_i == A_RLD_HI);

  assign updn_mode = down_q & ~clko_q;
  assign ovf_base  = wr_ctrl ? wr_data_i[CB_OVF] : ovf_q;
  assign xf_base   = wr_ctrl ? wr_data_i[CB_XF]  : xf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ext_q    <= 1'b0;
      ien_q    <= 1'b0;
      clko_q   <= 1'b0;
      down_q   <= 1'b0;
      ovf_q    <= 1'b0;
      xf_q     <= 1'b0;
      rld_lo_q <= '0;
      rld_hi_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wr_data_i[CB_RUN];
        ext_q <= wr_data_i[CB_EXT];
        ien_q <= wr_data_i[CB_IEN];
      end
      if (wr_mode) begin
        clko_q <= wr_data_i[MB_CLKO];
        down_q <= wr_data_i[MB_DOWN];
      end
      if (wr_rlo) rld_lo_q <= wr_data_i;
      if (wr_rhi) rld_hi_q <= wr_data_i;
      ovf_q <= ovf_base | wrap_i;
      xf_q  <= xf_base ^ (wrap_i & updn_mode);
    end
  end

  assign cfg_o = '{run: run_q, ext_sel: ext_q, irq_en: ien_q,
                   clko_en: clko_q, down_en: down_q};
  assign rld_o = {rld_hi_q, rld_lo_q};
  assign ovf_o = ovf_q;
  assign xf_o  = xf_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[CB_RUN] = run_q;
        rd_data_o[CB_EXT] = ext_q;
        rd_data_o[CB_IEN] = ien_q;
        rd_data_o[CB_XF]  = xf_q;
        rd_data_o[CB_OVF] = ovf_q;
      end
      A_MODE: begin
        rd_data_o[MB_CLKO] = clko_q;
        rd_data_o[MB_DOWN] = down_q;
      end
      A_CNT_LO: rd_data_o = cnt_i[HALF_W-1:0];
      A_CNT_HI: rd_data_o = cnt_i[2*HALF_W-1:HALF_W];
      A_RLD_LO: rd_data_o = rld_lo_q;
      A_RLD_HI: rd_data_o = rld_hi_q;
      default:  rd_data_o = '0;
    endcase
  end

  p_ovf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q)
    else $error("p_ovf_set_r10");

  p_xf_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && updn_mode && !wr_ctrl) |=> (xf_q != $past(xf_q)))
    else $error("p_xf_toggle_r7");

  p_xf_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wrap_i && updn_mode) && !wr_ctrl) |=> $stable(xf_q))
    else $error("p_xf_quiet_r7");

endmodule

// File: rtl/tmr_clkout.sv
module tmr_clkout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  output logic out_o
);

  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              out_q <= 1'b0;
    else if (en_i && wrap_i)  out_q <= ~out_q;
  end

  assign out_o = out_q;

  p_clko_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_i) |=> (out_q != $past(out_q)))
    else $error("p_clko_toggle_r8");

  p_clko_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && wrap_i) |=> $stable(out_q))
    else $error("p_clko_hold_r8");

endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_tmr_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              dir_pin_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              ovf_o,
  output logic              xflg_o,
  output logic              irq_o,
  output logic              clkout_o
);

  localparam int W = 2 * HALF_W;

  cfg_t         cfg;
  logic [W-1:0] rld;
  logic [W-1:0] cnt;
  logic         evt, up, wrap;
  logic         wr_lo, wr_hi;
  logic         ovf, xf;

  tmr_regs #(.HALF_W(HALF_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .cnt_i       (cnt),
    .wrap_i      (wrap),
    .cfg_o       (cfg),
    .rld_o       (rld),
    .ovf_o       (ovf),
    .xf_o        (xf),
    .wr_cnt_lo_o (wr_lo),
    .wr_cnt_hi_o (wr_hi)
  );

  tmr_event_gen #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg),
    .tick_i (tick_i),
    .pin_i  (cnt_pin_i),
    .dir_i  (dir_pin_i),
    .evt_o  (evt),
    .up_o   (up)
  );

  tmr_count_core #(.HALF_W(HALF_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .up_i    (up),
    .rld_i   (rld),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (wr_data_i),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  tmr_clkout u_clko (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg.clko_en),
    .wrap_i (wrap),
    .out_o  (clkout_o)
  );

  assign ovf_o  = ovf;
  assign xflg_o = xf;
  assign irq_o  = cfg.irq_en & (ovf | xf);

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cfg.irq_en && (ovf_o || xflg_o)))
    else $error("p_irq_gate_r11");

  p_irq_raise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.irq_en && wrap) |=> (irq_o || !cfg.irq_en))
    else $error("p_irq_raise_r11");

endmodule

// File: tb/updn_reload_timer_tb.sv
`timescale 1ns/1ps
module updn_reload_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       dir_pin = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       ovf_o, xflg_o, irq_o, clkout_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [15:0] m_cnt = '0, m_rld = '0;
  bit m_run, m_ext, m_ien, m_ovf, m_xf, m_ce, m_de, m_dir, m_clk;
  bit m_s0, m_s1, m_prev;

  always #2.5 clk = ~clk;

  updn_reload_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin),
    .dir_pin_i(dir_pin), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ovf_o(ovf_o), .xflg_o(xflg_o), .irq_o(irq_o), .clkout_o(clkout_o)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock edge of the requirements-level model
  task automatic model_step(bit t, bit we, logic [2:0] wa, logic [7:0] wd);
    bit fall = m_prev && !m_s1;
    bit ce = m_ce, de = m_de;
    bit evt = m_run && ((m_ext && !ce) ? fall : t);
    bit up = ce || !de || m_dir;
    bit cw = we && (wa == 3'd2 || wa == 3'd3);
    bit wrap = 0;
    if (evt && !cw) begin
      if (up) begin
        if (m_cnt == 16'hFFFF) begin m_cnt = m_rld; wrap = 1; end
        else m_cnt = m_cnt + 16'd1;
      end else begin
        if (m_cnt == m_rld) begin m_cnt = 16'hFFFF; wrap = 1; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
    if (we) begin
      case (wa)
        3'd0: begin m_run = wd[0]; m_ext = wd[1]; m_ien = wd[2]; m_xf = wd[6]; m_ovf = wd[7]; end
        3'd1: begin m_ce = wd[0]; m_de = wd[1]; end
        3'd2: m_cnt[7:0] = wd;
        3'd3: m_cnt[15:8] = wd;
        3'd4: m_rld[7:0] = wd;
        3'd5: m_rld[15:8] = wd;
        default: ;
      endcase
    end
    if (wrap) begin
      m_ovf = 1;
      if (de && !ce) m_xf = !m_xf;
      if (ce) m_clk = !m_clk;
    end
    m_prev = m_s1; m_s1 = m_s0; m_s0 = cnt_pin;
    m_dir = dir_pin;
  endtask

  task automatic cyc(bit t, bit we = 0, logic [2:0] wa = '0, logic [7:0] wd = '0);
    tick_i = t; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    model_step(t, we, wa, wd);
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(0, 1, a, d);
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr_i = a; #0.1; d = rd_data_o;
  endtask

  task automatic check_all(string tag);
    logic [7:0] d;
    rd(3'd0, d); chk(tag, "ctrl", {8'h0, d}, {8'h0, m_ovf, m_xf, 3'b000, m_ien, m_ext, m_run});
    rd(3'd1, d); chk(tag, "mode", {8'h0, d}, {14'h0, m_de, m_ce});
    rd(3'd2, d); chk(tag, "cnt_lo", {8'h0, d}, {8'h0, m_cnt[7:0]});
    rd(3'd3, d); chk(tag, "cnt_hi", {8'h0, d}, {8'h0, m_cnt[15:8]});
    rd(3'd4, d); chk(tag, "rld_lo", {8'h0, d}, {8'h0, m_rld[7:0]});
    rd(3'd5, d); chk(tag, "rld_hi", {8'h0, d}, {8'h0, m_rld[15:8]});
    chk(tag, "ovf_o", {15'h0, ovf_o}, {15'h0, m_ovf});
    chk(tag, "xflg_o", {15'h0, xflg_o}, {15'h0, m_xf});
    chk(tag, "irq_o", {15'h0, irq_o}, {15'h0, m_ien && (m_ovf || m_xf)});
    chk(tag, "clkout_o", {15'h0, clkout_o}, {15'h0, m_clk});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2/R3/R4: up counting with direction pin low and down-enable off
    wr(3'd0, 8'h01); wr(3'd4, 8'h34); wr(3'd5, 8'h12); set_cnt(16'hFFFD);
    dir_pin = 1'b0;
    cyc(1); cyc(1); check_all("R2"); check_all("R4");
    cyc(1); check_all("R3");
    cyc(0); cyc(0); check_all("R2");
    wr(3'd0, 8'h80); cyc(1); cyc(1); check_all("R2");
    wr(3'd0, 8'h01); check_all("R10");

    // R5/R6/R7: down counting
    wr(3'd1, 8'h02); set_cnt(16'h1236);
    cyc(1); cyc(1); check_all("R5");
    cyc(1); check_all("R6"); check_all("R7");
    dir_pin = 1'b1; cyc(1); check_all("R5");
    cyc(1); check_all("R7");
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); dir_pin = 1'b0; cyc(0);
    cyc(1); cyc(1); check_all("R6");
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);

    // R11: interrupt request
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); check_all("R11");
    set_cnt(16'hFFFF); cyc(1); check_all("R11");
    wr(3'd0, 8'h05); check_all("R11");

    // R10: flag clear racing a wrap
    set_cnt(16'hFFFF); cyc(1, 1, 3'd0, 8'h05); check_all("R10");

    // R8: clock-out mode ignores down-enable and direction
    wr(3'd0, 8'h01); wr(3'd1, 8'h03); dir_pin = 1'b0; set_cnt(16'hFFFE);
    cyc(1); cyc(1); check_all("R8");
    set_cnt(16'hFFFF); cyc(1); check_all("R8");
    wr(3'd1, 8'h02); set_cnt(16'h1234); cyc(1); check_all("R8");

    // R9: external falling edges, tick ignored
    wr(3'd1, 8'h00); wr(3'd0, 8'h03); set_cnt(16'h0000);
    for (int i = 0; i < 4; i++) begin
      cnt_pin = 1'b0; repeat (4) cyc(1);
      cnt_pin = 1'b1; repeat (4) cyc(1);
    end
    check_all("R9");

    // R12: count write beats event; unused addresses read zero
    wr(3'd0, 8'h01); set_cnt(16'hFFFF);
    cyc(1, 1, 3'd2, 8'h10); check_all("R12");
    rd(3'd6, d); chk("R12", "addr6", {8'h0, d}, 16'h0);
    rd(3'd7, d); chk("R12", "addr7", {8'h0, d}, 16'h0);

    // random phase across R2, R3, R5, R6, R7, R8, R10
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 9) == 0) dir_pin = ~dir_pin;
      if (r < 3) wr(3'd0, ($urandom_range(0, 255) & 8'hC4) | 8'h01);
      else if (r < 5) wr(3'd1, 8'($urandom_range(0, 3)));
      else if (r < 7) wr(3'($urandom_range(4, 5)), 8'($urandom_range(0, 255)));
      else if (r < 9) set_cnt(m_rld + 16'd3);
      else if (r < 11) set_cnt(16'hFFFC);
      else cyc(bit'($urandom_range(0, 1)));
      check_all("R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule